// File: doc/BRIEF.md
# System Control Register File

This block is a bank of 32-bit control and status words on a simple memory-mapped register bus. The bus has a 12-bit byte address, separate write and read strobes, write data and registered read data. It decodes a 4 KiB window. Only the lower part of that window has storage behind it: 512 words, selected by the byte address divided by four.

At reset, four words load fixed identification values and all other words clear to zero. A few status locations report two high bits as set on every read. The stored word behind those locations does not change.

One byte offset above the storage, 0xF00, is a power-control command port. Writing a command value there raises a one-cycle pulse that asks the rest of the system to reset or to shut down. Any other access above the storage range is a bad access. Such a write stores nothing, such a read returns zero, and either one raises a one-cycle error pulse.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset, reads at byte offsets 0x100, 0x104, 0x108 and 0x10C return 0x35F20121, 0x00000002, 0x35F30121 and 0x35F40121. These are the reset contents 0x05F20121, 0x00000002, 0x05F30121 and 0x05F40121, with the status bits of R4 applied.
- R2: After reset, every storage word that R1 does not name reads as zero.
- R3: A write to a byte offset below 0x800 stores all 32 bits of the write data. The word index is the offset divided by four, so address bits [1:0] are ignored. Read data appears on bus_rdata in the cycle after the read strobe and holds until the next read.
- R4: Reads at byte offsets 0x100, 0x108 and 0x10C return the stored word OR 0x30000000. Reads at all other offsets return the stored word unchanged.
- R5: A write of 1 or 2 to byte offset 0xF00 makes sys_rst_req high for exactly the one cycle after the write.
- R6: A write of 3 to byte offset 0xF00 makes sys_shdn_req high for exactly the one cycle after the write. sys_rst_req and sys_shdn_req are never high together.
- R7: A write to 0xF00 of any value other than 1, 2 or 3 raises no request pulse and no bad-access pulse. No access to 0xF00 ever raises bad_access.
- R8: A write to an offset of 0x800 or above, other than 0xF00, changes no stored word and pulses bad_access for the one cycle after the write.
- R9: A read from an offset of 0x800 or above returns zero in the next cycle. Unless the offset is 0xF00, it also pulses bad_access for that cycle.
- R10: When read and write strobes arrive in the same cycle at the same in-range word, the read returns the value the word held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address within the window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sys_rst_req | output | 1 | One-cycle system reset request |
| sys_shdn_req | output | 1 | One-cycle system shutdown request |
| bad_access | output | 1 | One-cycle out-of-range access pulse |

## Verification
The checker examines the power-command decode, the error pulse and the zero data returned for out-of-range reads on every cycle. It checks that each request pulse follows exactly one matching command write, that the two requests are mutually exclusive, and that bad_access follows only an out-of-range access away from the command offset. Only the bench scenarios can show stored contents: the reset values, full-width write-back, the status bits forced on reads, and the fact that out-of-range writes do not alias onto a stored word.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned NUM_WORDS = 512;
  localparam logic [ADDR_W-1:0] PWR_OFS   = 12'hF00;
  localparam logic [DATA_W-1:0] STAT_BITS = 32'h3000_0000;

  typedef enum logic [1:0] {PWR_NONE, PWR_RESET, PWR_SHUTDOWN} pwr_cmd_e;

  // Reset content of a storage word, by word index.
  function automatic logic [DATA_W-1:0] reset_word(input int unsigned idx);
    case (idx)
      32'h40:  return 32'h05F2_0121;
      32'h41:  return 32'h0000_0002;
      32'h42:  return 32'h05F3_0121;
      32'h43:  return 32'h05F4_0121;
      default: return '0;
    endcase
  endfunction

  // Word indices whose reads carry the forced status bits.
  function automatic logic is_status_word(input logic [ADDR_W-1:0] word);
    return (word == 'h40) || (word == 'h42) || (word == 'h43);
  endfunction

  // Power command decode from written data.
  function automatic pwr_cmd_e decode_cmd(input logic [DATA_W-1:0] val);
    if (val == 32'd1 || val == 32'd2) return PWR_RESET;
    if (val == 32'd3) return PWR_SHUTDOWN;
    return PWR_NONE;
  endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int unsigned AW     = ADDR_W,
  parameter int unsigned NWORDS = NUM_WORDS,
  parameter logic [AW-1:0] CMD_OFS = PWR_OFS,
  localparam int unsigned IW    = $clog2(NWORDS)
) (
  input  logic [AW-1:0] addr,
  output logic          in_range,
  output logic          is_cmd,
  output logic          is_stat,
  output logic [IW-1:0] widx
);
  logic [AW-1:0] word;
  logic [AW-1:0] cmd_word;

  always_comb begin
    word     = addr >> 2;
    cmd_word = CMD_OFS >> 2;
    in_range = (32'(word) < NWORDS);
    is_cmd   = (word == cmd_word);
    is_stat  = is_status_word(word);
    widx     = word[IW-1:0];
  end
endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
  import sysctl_pkg::*;
#(
  parameter int unsigned DW     = DATA_W,
  parameter int unsigned NWORDS = NUM_WORDS,
  parameter logic [DW-1:0] OR_BITS = STAT_BITS,
  localparam int unsigned IW    = $clog2(NWORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          re,
  input  logic          rd_ok,
  input  logic          rd_stat,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [NWORDS];
  logic [DW-1:0] rd_word;

  always_comb begin
    rd_word = rd_ok ? mem[widx] : '0;
    if (rd_ok && rd_stat) rd_word = rd_word | OR_BITS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(NWORDS); i++) mem[i] <= reset_word(i);
      rdata <= '0;
    end else begin
      if (we) mem[widx] <= wdata;
      if (re) rdata <= rd_word;
    end
  end
endmodule

// File: rtl/sysctl_pwrcmd.sv
module sysctl_pwrcmd
  import sysctl_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [DW-1:0] cmd_val,
  output logic          rst_req,
  output logic          shdn_req
);
  pwr_cmd_e cmd;

  always_comb cmd = cmd_wr ? decode_cmd(cmd_val) : PWR_NONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_req  <= 1'b0;
      shdn_req <= 1'b0;
    end else begin
      rst_req  <= (cmd == PWR_RESET);
      shdn_req <= (cmd == PWR_SHUTDOWN);
    end
  end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int unsigned AW     = ADDR_W,
  parameter int unsigned DW     = DATA_W,
  parameter int unsigned NWORDS = NUM_WORDS,
  localparam int unsigned IW    = $clog2(NWORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          sys_rst_req,
  output logic          sys_shdn_req,
  output logic          bad_access
);
  logic          in_range;
  logic          is_cmd;
  logic          is_stat;
  logic [IW-1:0] widx;
  logic          store_we;
  logic          cmd_wr;
  logic          oob_evt;

  sysctl_decode #(.AW(AW), .NWORDS(NWORDS), .CMD_OFS(AW'(PWR_OFS))) u_dec (
    .addr(bus_addr), .in_range(in_range), .is_cmd(is_cmd),
    .is_stat(is_stat), .widx(widx)
  );

  assign store_we = bus_wr && in_range;
  assign cmd_wr   = bus_wr && is_cmd;
  assign oob_evt  = (bus_wr || bus_rd) && !in_range && !is_cmd;

  sysctl_store #(.DW(DW), .NWORDS(NWORDS), .OR_BITS(DW'(STAT_BITS))) u_store (
    .clk(clk), .rst_n(rst_n), .we(store_we), .re(bus_rd), .rd_ok(in_range),
    .rd_stat(is_stat), .widx(widx), .wdata(bus_wdata), .rdata(bus_rdata)
  );

  sysctl_pwrcmd #(.DW(DW)) u_pwr (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_val(bus_wdata),
    .rst_req(sys_rst_req), .shdn_req(sys_shdn_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) bad_access <= 1'b0;
    else        bad_access <= oob_evt;
  end
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] bus_addr,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        sys_rst_req,
  input logic        sys_shdn_req,
  input logic        bad_access
);
  logic cmd_ofs;
  logic high_ofs;
  assign cmd_ofs  = (bus_addr[11:2] == 10'h3C0);
  assign high_ofs = bus_addr[11];

  // R5
  rst_req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(bus_wr && cmd_ofs && (bus_wdata == 32'd1 || bus_wdata == 32'd2)));

  // R5
  rst_req_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && cmd_ofs && (bus_wdata == 32'd1 || bus_wdata == 32'd2)) |=> sys_rst_req);

  // R6
  shdn_req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_shdn_req |-> $past(bus_wr && cmd_ofs && bus_wdata == 32'd3));

  // R6
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_rst_req && sys_shdn_req));

  // R8
  bad_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> $past((bus_wr || bus_rd) && high_ofs && !cmd_ofs));

  // R9
  oob_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && high_ofs) |=> (bus_rdata == 32'h0));
endmodule

bind sysctl_regfile sysctl_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_rst_req(sys_rst_req),
  .sys_shdn_req(sys_shdn_req), .bad_access(bad_access)
);

// File: tb/sysctl_regfile_tb_top.sv
module sysctl_regfile_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sys_rst_req;
  logic        sys_shdn_req;
  logic        bad_access;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_rst_req(sys_rst_req),
    .sys_shdn_req(sys_shdn_req), .bad_access(bad_access)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Status bit model: offsets 0x100, 0x108, 0x10C show bits 29:28 set.
  function automatic logic [31:0] view(input logic [11:0] a, input logic [31:0] v);
    logic [11:0] al = {a[11:2], 2'b00};
    if (al == 12'h100 || al == 12'h108 || al == 12'h10C) return v | 32'h3000_0000;
    return v;
  endfunction

  // Write; returns {rst, shdn, bad} seen in the following cycle.
  task automatic do_write(input logic [11:0] a, input logic [31:0] d, output logic [2:0] ev);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    ev = {sys_rst_req, sys_shdn_req, bad_access};
    @(negedge clk);
  endtask

  task automatic do_read(input logic [11:0] a, output logic [31:0] d, output logic bad);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata; bad = bad_access;
  endtask

  task automatic t_reset_values();
    logic [31:0] d; logic b;
    do_read(12'h100, d, b); check("R1 0x100", d, 32'h35F2_0121);
    do_read(12'h104, d, b); check("R1 0x104", d, 32'h0000_0002);
    do_read(12'h108, d, b); check("R1 0x108", d, 32'h35F3_0121);
    do_read(12'h10C, d, b); check("R1 0x10C", d, 32'h35F4_0121);
    do_read(12'h000, d, b); check("R2 0x000", d, 32'h0);
    do_read(12'h0FC, d, b); check("R2 0x0FC", d, 32'h0);
    do_read(12'h110, d, b); check("R2 0x110", d, 32'h0);
    do_read(12'h7FC, d, b); check("R2 0x7FC", d, 32'h0);
  endtask

  task automatic t_write_read();
    logic [31:0] d; logic b; logic [2:0] ev;
    do_write(12'h010, 32'hDEAD_BEEF, ev); check("R3 no event", 32'(ev), 32'h0);
    do_read(12'h010, d, b); check("R3 readback", d, 32'hDEAD_BEEF);
    do_write(12'h7FF, 32'hA5A5_5A5A, ev);
    do_read(12'h7FC, d, b); check("R3 low bits ignored", d, 32'hA5A5_5A5A);
    check("R3 no bad on in-range", 32'(b), 32'h0);
    repeat (3) @(negedge clk);
    check("R3 rdata holds", bus_rdata, 32'hA5A5_5A5A);
    do_write(12'h104, 32'hFFFF_FFFF, ev);
    do_read(12'h104, d, b); check("R3 full width", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_status_bits();
    logic [31:0] d; logic b; logic [2:0] ev;
    do_write(12'h100, 32'h0000_0000, ev);
    do_read(12'h100, d, b); check("R4 0x100 forced", d, view(12'h100, 32'h0));
    do_write(12'h108, 32'h0000_1234, ev);
    do_read(12'h10A, d, b); check("R4 0x108 forced", d, view(12'h108, 32'h1234));
    do_write(12'h10C, 32'hC000_0000, ev);
    do_read(12'h10C, d, b); check("R4 0x10C forced", d, 32'hF000_0000);
    do_write(12'h0C0, 32'h0000_0001, ev);
    do_read(12'h0C0, d, b); check("R4 other offset plain", d, 32'h1);
  endtask

  task automatic t_power();
    logic [2:0] ev; logic [31:0] d; logic b;
    do_write(12'hF00, 32'd1, ev); check("R5 value 1", 32'(ev), 32'b100);
    check("R5 pulse ends", 32'({sys_rst_req, sys_shdn_req}), 32'h0);
    do_write(12'hF00, 32'd2, ev); check("R5 value 2", 32'(ev), 32'b100);
    do_write(12'hF02, 32'd3, ev); check("R6 value 3", 32'(ev), 32'b010);
    check("R6 pulse ends", 32'({sys_rst_req, sys_shdn_req}), 32'h0);
    do_write(12'hF00, 32'd0, ev); check("R7 value 0", 32'(ev), 32'b000);
    do_write(12'hF00, 32'd4, ev); check("R7 value 4", 32'(ev), 32'b000);
    do_write(12'hF00, 32'h1_0001, ev); check("R7 wide value", 32'(ev), 32'b000);
    do_read(12'hF00, d, b);
    check("R7 read of cmd not bad", 32'(b), 32'h0);
    check("R9 read of cmd zero", d, 32'h0);
  endtask

  task automatic t_out_of_range();
    logic [2:0] ev; logic [31:0] d; logic b;
    do_write(12'h020, 32'h1111_2222, ev);
    do_write(12'h820, 32'h9999_8888, ev); check("R8 write bad pulse", 32'(ev), 32'b001);
    check("R8 pulse ends", 32'(bad_access), 32'h0);
    do_read(12'h020, d, b); check("R8 no alias store", d, 32'h1111_2222);
    do_write(12'h800, 32'h5, ev); check("R8 edge 0x800", 32'(ev), 32'b001);
    do_read(12'h000, d, b); check("R8 word 0 untouched", d, 32'h0);
    do_read(12'h820, d, b);
    check("R9 read zero", d, 32'h0);
    check("R9 read bad", 32'(b), 32'h1);
    do_read(12'hFFC, d, b); check("R9 top read bad", 32'(b), 32'h1);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    bus_addr = 12'h030; bus_wdata = 32'h0BAD_F00D; bus_wr = 1'b1;
    @(negedge clk);
    bus_wdata = 32'h1357_9BDF; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R10 read sees old word", bus_rdata, 32'h0BAD_F00D);
    @(negedge clk);
    bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check("R10 write landed", bus_rdata, 32'h1357_9BDF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R2 rdata at reset", bus_rdata, 32'h0);
    check("R5 no pulses at reset", 32'({sys_rst_req, sys_shdn_req, bad_access}), 32'h0);
    rst_n = 1'b1;
    t_reset_values();
    t_write_read();
    t_status_bits();
    t_power();
    t_out_of_range();
    t_same_cycle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule